// File: doc/BRIEF.md
# Dual-Port Double-Data-Rate Burst SRAM

This block is a synthesizable model of a burst static memory with one port used only for reads and one used only for writes. Both ports share a single address bus. Every access moves a pair of words: word 0 and then word 1 of the addressed location. The clock stands in for the input clock pair. Its rising edge plays the true clock and its falling edge plays the complement. The output clock is the same clock, so there is no separate output clock domain.

A read is launched on a rising edge and samples the address at that edge. A write is launched on a rising edge, where it takes word 0 and its byte strobes. On the falling edge that follows, it takes its address, word 1 and that word's strobes. The shared bus therefore carries the read address in the low phase and the write address in the high phase, so one read and one write can start in every cycle. A write reaches the storage array on the next rising edge. A read launched on that edge still sees the newest data, because the pending write is merged into the read lane by lane.

The output has no tri-state driver. It carries a registered valid flag beside the data bus, and the data bus reads zero while the flag is low.

Top module: `qdr_burst_sram`

## Requirements
- R1: While reset is asserted and after it is released, the block starts with both ports idle. `rvalid` is 0, and `rdata` is all zeros whenever `rvalid` is 0.
- R2: A read launched on rising edge t (`rd_sel_n` low) shows word 0 of the addressed location in the low phase after the falling edge of cycle t+1. It then shows word 1 in the high phase after rising edge t+2. `rvalid` is 1 in both phases.
- R3: A write launched on rising edge t stores word 0 taken at that edge and word 1 taken at the next falling edge. Both go into the location whose address is on the bus at that falling edge.
- R4: `wbe_n` is active low and is sampled with each data word on its own. Bit 0 guards data bits 8:0 and bit 1 guards bits 17:9. A lane whose strobe is high keeps its stored value.
- R5: A read launched on the rising edge right after a write to the same location returns that write's data. Lanes the write masked keep the stored contents.
- R6: Reads and writes work independently in the same cycle. A read launched on the same edge as a write to the same address returns the data stored before that write.
- R7: A cycle with `rd_sel_n` high produces no output burst. `rvalid` stays low in both phases two cycles later, while reads on consecutive edges give an unbroken run of valid words.
- R8: With `wr_sel_n` high at a rising edge, no location changes, whatever is driven on `wdata`, `wbe_n` or `addr`.
- R9: With both ports deselected, activity on the address and data inputs changes neither the output nor the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is the true phase, falling edge the complement |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_sel_n | input | 1 | Active-low read launch, sampled on rising edge |
| wr_sel_n | input | 1 | Active-low write launch, sampled on rising edge |
| addr | input | AW | Shared address: read address at rising edge, write address at falling edge |
| wdata | input | DW | Write data: word 0 at rising edge, word 1 at falling edge |
| wbe_n | input | NB | Active-low byte lane strobes, sampled with each data word |
| rdata | output | DW | Read data: word 0 in low phase, word 1 in high phase |
| rvalid | output | 1 | High while `rdata` carries a read word (models the driven state) |

## Verification
Directed full-width writes fill every location, and paired read-backs then tell whether word 0 and word 1 come out in the right phase and with the right latency. Writes with mixed strobe patterns, including fully masked ones, test whether the lanes really keep their stored values. A read right after a write to the same address shows whether forwarding works, and a read on the same edge as that write shows that it does not forward too early. Random traffic with frequent address collisions, idle cycles and garbage on deselected inputs then compares every output phase against a bench model updated in launch order.

// File: rtl/qdr_pkg.sv
package qdr_pkg;
  // Default geometry of the model
  localparam int unsigned DATA_W_DEF  = 18;
  localparam int unsigned LANES_DEF   = 2;
  localparam int unsigned ADDR_W_DEF  = 4;
  // Sync stages on reset release
  localparam int unsigned RST_STAGES  = 2;
endpackage

// File: rtl/qdr_rst_sync.sv
module qdr_rst_sync #(
  parameter int unsigned STAGES = qdr_pkg::RST_STAGES
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/qdr_wr_capture.sv
module qdr_wr_capture #(
  parameter int unsigned DW = qdr_pkg::DATA_W_DEF,
  parameter int unsigned NB = qdr_pkg::LANES_DEF,
  parameter int unsigned AW = qdr_pkg::ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wbe_n,
  output logic          cmt_en,
  output logic [AW-1:0] cmt_addr,
  output logic [DW-1:0] cmt_d0,
  output logic [DW-1:0] cmt_d1,
  output logic [NB-1:0] cmt_m0,
  output logic [NB-1:0] cmt_m1
);
  // true-phase stage: launch flag, word 0, lane mask 0
  logic          act_q, act_d;
  logic [DW-1:0] d0_q;
  logic [NB-1:0] m0_q;
  // complement-phase stage: address, word 1, lane mask 1
  logic          pend_q, pend_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] d1_q;
  logic [NB-1:0] m1_q;

  always_comb begin
    act_d  = !wr_sel_n;
    pend_d = act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  always_ff @(posedge clk) begin
    if (act_d) begin
      d0_q <= wdata;
      m0_q <= ~wbe_n;
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(negedge clk) begin
    if (act_q) begin
      addr_q <= addr;
      d1_q   <= wdata;
      m1_q   <= ~wbe_n;
    end
  end

  assign cmt_en   = pend_q;
  assign cmt_addr = addr_q;
  assign cmt_d0   = d0_q;
  assign cmt_d1   = d1_q;
  assign cmt_m0   = m0_q;
  assign cmt_m1   = m1_q;
endmodule

// File: rtl/qdr_store.sv
module qdr_store #(
  parameter int unsigned DW = qdr_pkg::DATA_W_DEF,
  parameter int unsigned NB = qdr_pkg::LANES_DEF,
  parameter int unsigned AW = qdr_pkg::ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          cmt_en,
  input  logic [AW-1:0] cmt_addr,
  input  logic [DW-1:0] cmt_d0,
  input  logic [DW-1:0] cmt_d1,
  input  logic [NB-1:0] cmt_m0,
  input  logic [NB-1:0] cmt_m1,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] fwd0,
  output logic [DW-1:0] fwd1
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LW    = DW / NB;

  logic [DW-1:0] bank0 [DEPTH];
  logic [DW-1:0] bank1 [DEPTH];
  logic [DW-1:0] old0, old1;
  logic [DW-1:0] new0, new1;
  logic          hit;

  assign old0 = bank0[cmt_addr];
  assign old1 = bank1[cmt_addr];

  // lane merge of pending write over current contents
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign new0[g*LW +: LW] = cmt_m0[g] ? cmt_d0[g*LW +: LW] : old0[g*LW +: LW];
    assign new1[g*LW +: LW] = cmt_m1[g] ? cmt_d1[g*LW +: LW] : old1[g*LW +: LW];
  end

  always_ff @(posedge clk) begin
    if (cmt_en) begin
      bank0[cmt_addr] <= new0;
      bank1[cmt_addr] <= new1;
    end
  end

  always_comb begin
    hit  = cmt_en && (cmt_addr == rd_addr);
    fwd0 = hit ? new0 : bank0[rd_addr];
    fwd1 = hit ? new1 : bank1[rd_addr];
  end
endmodule

// File: rtl/qdr_rd_pipe.sv
module qdr_rd_pipe #(
  parameter int unsigned DW = qdr_pkg::DATA_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic [DW-1:0] fwd0,
  input  logic [DW-1:0] fwd1,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          s1_act, s2_act, q1_val, q0_val;
  logic [DW-1:0] s1_w0, s1_w1, s2_w0, s2_w1, q1_w, q0_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_act <= 1'b0;
      s2_act <= 1'b0;
      q1_val <= 1'b0;
    end else begin
      s1_act <= rd_go;
      s2_act <= s1_act;
      q1_val <= s2_act;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_go) begin
      s1_w0 <= fwd0;
      s1_w1 <= fwd1;
    end
    if (s1_act) begin
      s2_w0 <= s1_w0;
      s2_w1 <= s1_w1;
    end
    if (s2_act) q1_w <= s2_w1;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q0_val <= 1'b0;
    else        q0_val <= s2_act;
  end

  always_ff @(negedge clk) begin
    if (s2_act) q0_w <= s2_w0;
  end

  // double-rate output select: word 1 in high phase, word 0 in low phase
  always_comb begin
    if (clk) begin
      rvalid = q1_val;
      rdata  = q1_val ? q1_w : '0;
    end else begin
      rvalid = q0_val;
      rdata  = q0_val ? q0_w : '0;
    end
  end
endmodule

// File: rtl/qdr_burst_sram.sv
module qdr_burst_sram #(
  parameter int unsigned DW = qdr_pkg::DATA_W_DEF,
  parameter int unsigned NB = qdr_pkg::LANES_DEF,
  parameter int unsigned AW = qdr_pkg::ADDR_W_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_sel_n,
  input  logic          wr_sel_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NB-1:0] wbe_n,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic          core_rst_n;
  logic          wr_commit;
  logic [AW-1:0] cmt_addr;
  logic [DW-1:0] cmt_d0, cmt_d1, fwd0, fwd1;
  logic [NB-1:0] cmt_m0, cmt_m1;

  qdr_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (core_rst_n)
  );

  qdr_wr_capture #(.DW(DW), .NB(NB), .AW(AW)) u_wr (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .wr_sel_n (wr_sel_n),
    .addr     (addr),
    .wdata    (wdata),
    .wbe_n    (wbe_n),
    .cmt_en   (wr_commit),
    .cmt_addr (cmt_addr),
    .cmt_d0   (cmt_d0),
    .cmt_d1   (cmt_d1),
    .cmt_m0   (cmt_m0),
    .cmt_m1   (cmt_m1)
  );

  qdr_store #(.DW(DW), .NB(NB), .AW(AW)) u_store (
    .clk      (clk),
    .cmt_en   (wr_commit),
    .cmt_addr (cmt_addr),
    .cmt_d0   (cmt_d0),
    .cmt_d1   (cmt_d1),
    .cmt_m0   (cmt_m0),
    .cmt_m1   (cmt_m1),
    .rd_addr  (addr),
    .fwd0     (fwd0),
    .fwd1     (fwd1)
  );

  qdr_rd_pipe #(.DW(DW)) u_rd (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .rd_go  (!rd_sel_n),
    .fwd0   (fwd0),
    .fwd1   (fwd1),
    .rdata  (rdata),
    .rvalid (rvalid)
  );
endmodule

// File: rtl/qdr_burst_sram_chk.sv
module qdr_burst_sram_chk #(
  parameter int unsigned DW = qdr_pkg::DATA_W_DEF
) (
  input logic          clk,
  input logic          rst_n,
  input logic          core_rst_n,
  input logic          rd_sel_n,
  input logic          wr_sel_n,
  input logic          commit_en,
  input logic [DW-1:0] rdata,
  input logic          rvalid
);
  // high once the core has seen a full cycle out of reset
  logic armed;
  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!rvalid);
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0));

  // R2
  rd_launch_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && !rd_sel_n) |=> ##1 rvalid);

  // R7
  rd_idle_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && rd_sel_n) |=> ##1 !rvalid);

  // R3
  wr_commit_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && !wr_sel_n) |=> commit_en);

  // R8
  wr_skip_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (armed && wr_sel_n) |=> !commit_en);
endmodule

bind qdr_burst_sram qdr_burst_sram_chk #(.DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .rd_sel_n   (rd_sel_n),
  .wr_sel_n   (wr_sel_n),
  .commit_en  (wr_commit),
  .rdata      (rdata),
  .rvalid     (rvalid)
);

// File: tb/qdr_burst_sram_tb_top.sv
module qdr_burst_sram_tb_top;
  localparam int DW = 18;
  localparam int NB = 2;
  localparam int AW = 4;
  localparam int LW = DW / NB;
  localparam int DEPTH = 1 << AW;
  localparam int MAXC = 1024;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          rd_sel_n, wr_sel_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic [NB-1:0] wbe_n;
  logic [DW-1:0] rdata;
  logic          rvalid;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  logic [DW-1:0] m0 [DEPTH];
  logic [DW-1:0] m1 [DEPTH];
  bit            exp_v [MAXC];
  logic [DW-1:0] exp0 [MAXC];
  logic [DW-1:0] exp1 [MAXC];
  string         exp_tag [MAXC];
  bit            lw_v = 1'b0;
  logic [AW-1:0] lw_a = '0;

  always #5 clk = ~clk;

  qdr_burst_sram #(.DW(DW), .NB(NB), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rd_sel_n(rd_sel_n), .wr_sel_n(wr_sel_n),
    .addr(addr), .wdata(wdata), .wbe_n(wbe_n), .rdata(rdata), .rvalid(rvalid)
  );

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nw,
                                          input logic [NB-1:0] ben);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NB; i++) if (!ben[i]) r[i*LW +: LW] = nw[i*LW +: LW];
    return r;
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  // compare one output phase with the read launched two cycles earlier
  task automatic check_out(input bit hi);
    int p = cyc - 2;
    if (p >= 0 && exp_v[p]) begin
      check("R2", DW'(rvalid), DW'(1));
      check(exp_tag[p], rdata, hi ? exp1[p] : exp0[p]);
    end else begin
      check("R7", DW'(rvalid), DW'(0));
      check("R1", rdata, '0);
    end
  endtask

  // called in the low phase, returns in the next low phase
  task automatic run_cycle(input bit rd, input logic [AW-1:0] ra,
                           input bit wr, input logic [AW-1:0] wa,
                           input logic [DW-1:0] d0, input logic [NB-1:0] b0,
                           input logic [DW-1:0] d1, input logic [NB-1:0] b1,
                           input string tag);
    check_out(1'b0);
    rd_sel_n = !rd;
    wr_sel_n = !wr;
    addr  = rd ? ra : AW'($urandom);
    wdata = wr ? d0 : DW'($urandom);
    wbe_n = wr ? b0 : NB'($urandom);
    exp_v[cyc] = rd;
    if (rd) begin
      exp0[cyc] = m0[ra];
      exp1[cyc] = m1[ra];
      if (lw_v && lw_a == ra)      exp_tag[cyc] = "R5";
      else if (wr && wa == ra)     exp_tag[cyc] = "R6";
      else                         exp_tag[cyc] = tag;
    end
    @(posedge clk); #2.5;
    check_out(1'b1);
    addr  = wr ? wa : AW'($urandom);
    wdata = wr ? d1 : DW'($urandom);
    wbe_n = wr ? b1 : NB'($urandom);
    if (wr) begin
      m0[wa] = merge(m0[wa], d0, b0);
      m1[wa] = merge(m1[wa], d1, b1);
    end
    lw_v = wr;
    lw_a = wa;
    cyc++;
    @(negedge clk); #2.5;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) run_cycle(0, '0, 0, '0, '0, '0, '0, '0, tag);
  endtask

  initial begin
    for (int i = 0; i < MAXC; i++) exp_v[i] = 1'b0;
    void'($urandom(32'd4177));
    rst_n = 1'b0; rd_sel_n = 1'b1; wr_sel_n = 1'b1;
    addr = '0; wdata = '0; wbe_n = '1;
    // R1: reset state in both phases
    repeat (2) @(negedge clk);
    #2.5;
    check("R1", DW'(rvalid), DW'(0));
    check("R1", rdata, '0);
    @(posedge clk); #2.5;
    check("R1", DW'(rvalid), DW'(0));
    @(negedge clk); #2.5;
    rst_n = 1'b1;
    idle(4, "R1");

    // R3: fill every location with full-width pairs
    for (int a = 0; a < DEPTH; a++)
      run_cycle(0, '0, 1, AW'(a), DW'(18'h01000 + a), '0, DW'(18'h22000 + a), '0, "R3");
    idle(2, "R3");
    // R2/R3: back-to-back reads, then an isolated read
    for (int a = 0; a < 4; a++) run_cycle(1, AW'(a), 0, '0, '0, '0, '0, '0, "R3");
    idle(2, "R7");
    run_cycle(1, 4'd9, 0, '0, '0, '0, '0, '0, "R2");
    idle(3, "R7");

    // R4: per-word lane strobes and a fully masked write
    run_cycle(0, '0, 1, 4'd3, 18'h3ffff, 2'b10, 18'h15555, 2'b01, "R4");
    run_cycle(0, '0, 1, 4'd4, 18'h2aaaa, 2'b11, 18'h0f0f0, 2'b11, "R4");
    idle(1, "R4");
    run_cycle(1, 4'd3, 0, '0, '0, '0, '0, '0, "R4");
    run_cycle(1, 4'd4, 0, '0, '0, '0, '0, '0, "R4");
    idle(2, "R4");

    // R5: read right after write, full and partial lanes
    run_cycle(0, '0, 1, 4'd5, 18'h12345, '0, 18'h2fedc, '0, "R5");
    run_cycle(1, 4'd5, 0, '0, '0, '0, '0, '0, "R5");
    run_cycle(0, '0, 1, 4'd5, 18'h00111, 2'b01, 18'h3fe00, 2'b10, "R5");
    run_cycle(1, 4'd5, 0, '0, '0, '0, '0, '0, "R5");
    idle(2, "R5");

    // R6: read and write on the same edge, same address
    run_cycle(1, 4'd7, 1, 4'd7, 18'h0beef, '0, 18'h1cafe, '0, "R6");
    run_cycle(1, 4'd7, 0, '0, '0, '0, '0, '0, "R6");
    run_cycle(1, 4'd8, 1, 4'd2, 18'h00aa5, '0, 18'h00a5a, '0, "R6");
    idle(2, "R6");

    // R8/R9: deselected ports with garbage on the bus, then read everything
    idle(6, "R9");
    run_cycle(1, 4'd2, 0, '0, '0, '0, '0, '0, "R8");
    for (int a = 0; a < DEPTH; a++) run_cycle(1, AW'(a), 0, '0, '0, '0, '0, '0, "R9");
    idle(2, "R9");

    // random mix with frequent address collisions
    for (int i = 0; i < 600; i++) begin
      bit            rd = ($urandom % 100) < 55;
      bit            wr = ($urandom % 100) < 55;
      logic [AW-1:0] ra = AW'($urandom % 6);
      logic [AW-1:0] wa = ($urandom % 2) ? ra : AW'($urandom);
      run_cycle(rd, ra, wr, wa, DW'($urandom), NB'($urandom),
                DW'($urandom), NB'($urandom), "R2");
    end
    idle(3, "R7");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule